// File: doc/BRIEF.md
# Switched-Weight Glitch Metric Monitor

This block watches a stream of digital-to-analog converter input codes, one per clock, and scores every transition between two consecutive codes. The score is a first-order glitch estimate: the number of analog unit weights whose switches change state. Each control bit that flips adds its own weight. The monitor first builds the switch-control word that a converter with the chosen coding scheme would drive, then compares it with the word built for the previous sample.

A parameter selects one of three coding schemes. In the plain binary scheme, bit j weighs 2^j units. In the segmented scheme, the top M code bits become a thermometer word and the remaining N-M bits stay binary; each thermometer line weighs 2^(N-M) units. In the layered split scheme, the code is split recursively M times. At each split, the MSB becomes a one-unit line, and the lower bits are ORed with that MSB for one half and ANDed with it for the other. The result is 2^M binary words of N-M bits and 2^M-1 one-unit lines.

The score appears one cycle after the second sample of a pair, with a valid flag. A running maximum of all scores since reset or since the last synchronous clear is also kept. The block is meant to sit beside a converter datapath model, or in a pattern checker, to compare coding schemes on real code streams.

Top module: `glitch_metric_mon`

## Requirements
- R1: After synchronous reset, `metric_valid` is 0, `metric` is 0 and `max_metric` is 0.
- R2: The first accepted sample (`in_valid`=1) after reset yields no score. Every later accepted sample raises `metric_valid` on the next cycle, with the score of the pair formed by that sample and the previously accepted one. A cycle with `in_valid`=0 gives `metric_valid`=0 on the next cycle and does not change the stored previous sample.
- R3: In binary mode (MODE=CODE_BINARY), the score is the sum of 2^j over the code bits j that differ, which is the numeric value of previous XOR current.
- R4: In segmented mode (MODE=CODE_SEGMENT), the top M bits drive a thermometer of 2^M-1 lines, each weighing 2^(N-M). The score is |t_prev - t_cur|·2^(N-M) plus the binary score of the low N-M bits.
- R5: In layered split mode (MODE=CODE_DECOMP), an n-bit word with MSB s and lower bits L splits into a one-unit line s, a word (L OR s) and a word (L AND s), each of n-1 bits. This is applied M times. The score is the binary-weighted toggle sum over all resulting words plus the count of toggled one-unit lines.
- R6: For the step from code 2^(N-1)-1 to code 2^(N-1), the score is 2^N-1 in binary mode, 2^(N-1)-1 with 2-bit segmentation, and 1 with one split layer.
- R7: Over an ascending sweep of all codes, the largest score with M split layers equals the largest score with (M+1)-bit segmentation.
- R8: `max_metric` is the largest score issued since reset or since the last cycle with `clr_max`=1. It is updated in the same cycle as `metric`. When `clr_max` is high, the register becomes 0 on the next edge, and the clear wins over a score arriving in that cycle.
- R9: A repeated code yields a valid score of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_max | input | 1 | Synchronous clear of the running maximum |
| in_valid | input | 1 | Sample present on `in_code` this cycle |
| in_code | input | N | Converter input code |
| metric_valid | output | 1 | `metric` holds a new score |
| metric | output | N | Weighted toggle count of the last pair |
| max_metric | output | N | Running maximum score |

## Verification
A corrupted stored control word shows up as a wrong score on the very next valid sample. A lost first-sample flag shows up as a spurious or missing `metric_valid` one cycle after the first accepted sample. A wrong weight assignment in any encoding leaves an exact mismatch against the arithmetic model somewhere in the exhaustive ascending and descending sweeps within 64 samples. A faulty maximum or clear path shows a wrong `max_metric` one cycle after the offending score or clear.

// File: rtl/glitch_mon_pkg.sv
package glitch_mon_pkg;

    typedef enum logic [1:0] {
        CODE_BINARY  = 2'd0,
        CODE_SEGMENT = 2'd1,
        CODE_DECOMP  = 2'd2
    } code_mode_e;

    // Number of switch-control lines for a coding scheme.
    function automatic int cw_width(code_mode_e md, int n, int m);
        case (md)
            CODE_SEGMENT: return (n - m) + (1 << m) - 1;
            CODE_DECOMP:  return (1 << m) * (n - m) + (1 << m) - 1;
            default:      return n;
        endcase
    endfunction

    // log2 of the unit-weight count of control line idx.
    function automatic int cw_wexp(code_mode_e md, int n, int m, int idx);
        case (md)
            CODE_SEGMENT: return (idx < n - m) ? idx : n - m;
            CODE_DECOMP:  return (idx < (1 << m) * (n - m)) ? idx % (n - m) : 0;
            default:      return idx;
        endcase
    endfunction

endpackage

// File: rtl/gm_therm_enc.sv
module gm_therm_enc #(
    parameter int TB = 2
) (
    input  logic [TB-1:0]      bin_in,
    output logic [(1<<TB)-2:0] therm_out
);
    localparam int THW = (1 << TB) - 1;

    always_comb begin
        for (int i = 0; i < THW; i++) begin
            therm_out[i] = (int'(bin_in) > i);
        end
    end

    // Lines fill from the bottom: no one above a zero.
    always_comb begin
        assert_therm_shape_R4: assert ((therm_out & (therm_out + THW'(1))) == '0);
    end
endmodule

// File: rtl/gm_ctrl_encode.sv
module gm_ctrl_encode
    import glitch_mon_pkg::*;
#(
    parameter int         N    = 6,
    parameter code_mode_e MODE = CODE_DECOMP,
    parameter int         M    = 2,
    parameter int         CW_W = cw_width(MODE, N, M)
) (
    input  logic [N-1:0]    code,
    output logic [CW_W-1:0] cw
);
    generate
        if (MODE == CODE_BINARY) begin : g_bin
            assign cw = code;
        end else if (MODE == CODE_SEGMENT) begin : g_seg
            if (M < N) begin : g_low
                assign cw[N-M-1:0] = code[N-M-1:0];
            end
            gm_therm_enc #(.TB(M)) u_therm (
                .bin_in    (code[N-1:N-M]),
                .therm_out (cw[CW_W-1:N-M])
            );
        end else begin : g_dec
            localparam int LEAVES = 1 << M;
            localparam int LW     = N - M;
            logic [N-1:0]        node [LEAVES];
            logic [LEAVES-2:0]   split_line;
            logic [N-1:0]        low_part;
            logic [N-1:0]        low_mask;
            logic                top_bit;

            always_comb begin
                for (int k = 0; k < LEAVES; k++) node[k] = '0;
                split_line = '0;
                low_part   = '0;
                low_mask   = '0;
                top_bit    = 1'b0;
                node[0]    = code;
                for (int l = 0; l < M; l++) begin
                    // descending k: children 2k, 2k+1 never overwrite an unread parent
                    for (int k = LEAVES - 1; k >= 0; k--) begin
                        if (k < (1 << l)) begin
                            low_mask  = (N'(1) << (N - 1 - l)) - N'(1);
                            top_bit   = node[k][N-1-l];
                            low_part  = node[k] & low_mask;
                            node[2*k]   = low_part | (top_bit ? low_mask : '0);
                            node[2*k+1] = top_bit ? low_part : '0;
                            split_line[(1 << l) - 1 + k] = top_bit;
                        end
                    end
                end
                cw = '0;
                for (int k = 0; k < LEAVES; k++) begin
                    for (int j = 0; j < LW; j++) begin
                        cw[k*LW + j] = node[k][j];
                    end
                end
                for (int s = 0; s < LEAVES - 1; s++) begin
                    cw[LEAVES*LW + s] = split_line[s];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gm_weight_sum.sv
module gm_weight_sum
    import glitch_mon_pkg::*;
#(
    parameter int         N    = 6,
    parameter code_mode_e MODE = CODE_DECOMP,
    parameter int         M    = 2,
    parameter int         CW_W = cw_width(MODE, N, M)
) (
    input  logic [CW_W-1:0] prev_cw,
    input  logic [CW_W-1:0] cur_cw,
    output logic [N-1:0]    total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (prev_cw[i] != cur_cw[i]) begin
                total = total + (N'(1) << cw_wexp(MODE, N, M, i));
            end
        end
    end

    always_comb begin
        if (prev_cw == cur_cw) begin
            assert_no_toggle_zero_R9: assert (total == '0);
        end
    end
endmodule

// File: rtl/glitch_metric_mon.sv
module glitch_metric_mon
    import glitch_mon_pkg::*;
#(
    parameter int         N    = 6,
    parameter code_mode_e MODE = CODE_DECOMP,
    parameter int         M    = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_max,
    input  logic         in_valid,
    input  logic [N-1:0] in_code,
    output logic         metric_valid,
    output logic [N-1:0] metric,
    output logic [N-1:0] max_metric
);
    localparam int CW_W = cw_width(MODE, N, M);

    typedef struct packed {
        logic         vld;
        logic [N-1:0] val;
    } score_t;

    logic [CW_W-1:0] cw_cur;
    logic [CW_W-1:0] cw_prev;
    logic            have_prev;
    logic [N-1:0]    step_sum;
    logic            pair_ok;
    score_t          score_q;
    logic [N-1:0]    max_q;

    gm_ctrl_encode #(.N(N), .MODE(MODE), .M(M), .CW_W(CW_W)) u_enc (
        .code (in_code),
        .cw   (cw_cur)
    );

    gm_weight_sum #(.N(N), .MODE(MODE), .M(M), .CW_W(CW_W)) u_sum (
        .prev_cw (cw_prev),
        .cur_cw  (cw_cur),
        .total   (step_sum)
    );

    assign pair_ok = in_valid && have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_prev   <= '0;
            have_prev <= 1'b0;
            score_q   <= '0;
            max_q     <= '0;
        end else begin
            score_q.vld <= pair_ok;
            if (pair_ok) score_q.val <= step_sum;
            if (in_valid) begin
                cw_prev   <= cw_cur;
                have_prev <= 1'b1;
            end
            if (clr_max) begin
                max_q <= '0;
            end else if (pair_ok && step_sum > max_q) begin
                max_q <= step_sum;
            end
        end
    end

    assign metric_valid = score_q.vld;
    assign metric       = score_q.val;
    assign max_metric   = max_q;

    assert_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !have_prev) |=> !metric_valid);

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !metric_valid);

    assert_max_covers_R8: assert property (@(posedge clk) disable iff (rst)
        (metric_valid && !$past(clr_max)) |-> (max_metric >= metric));

    assert_max_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_max |=> (max_metric >= $past(max_metric)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr_max |=> (max_metric == '0));
endmodule

// File: tb/tb_glitch_metric_mon.sv
module tb_glitch_metric_mon;
    import glitch_mon_pkg::*;

    localparam int NB = 6;
    localparam int ND = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_max = 1'b0;
    logic in_valid = 1'b0;
    logic [NB-1:0] in_code = '0;

    logic          mv [ND];
    logic [NB-1:0] mt [ND];
    logic [NB-1:0] mx [ND];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int prev_code = 0;
    bit have_prev = 0;
    int maxe [ND];

    always #5 clk = ~clk;

    // 0: binary, 1: 2-bit seg, 2: 3-bit seg, 3: 1 layer split, 4: 2 layer split
    glitch_metric_mon #(.N(NB), .MODE(CODE_BINARY), .M(1)) dut (
        .clk(clk), .rst(rst), .clr_max(clr_max), .in_valid(in_valid), .in_code(in_code),
        .metric_valid(mv[0]), .metric(mt[0]), .max_metric(mx[0]));
    glitch_metric_mon #(.N(NB), .MODE(CODE_SEGMENT), .M(2)) dut_s2 (
        .clk(clk), .rst(rst), .clr_max(clr_max), .in_valid(in_valid), .in_code(in_code),
        .metric_valid(mv[1]), .metric(mt[1]), .max_metric(mx[1]));
    glitch_metric_mon #(.N(NB), .MODE(CODE_SEGMENT), .M(3)) dut_s3 (
        .clk(clk), .rst(rst), .clr_max(clr_max), .in_valid(in_valid), .in_code(in_code),
        .metric_valid(mv[2]), .metric(mt[2]), .max_metric(mx[2]));
    glitch_metric_mon #(.N(NB), .MODE(CODE_DECOMP), .M(1)) dut_d1 (
        .clk(clk), .rst(rst), .clr_max(clr_max), .in_valid(in_valid), .in_code(in_code),
        .metric_valid(mv[3]), .metric(mt[3]), .max_metric(mx[3]));
    glitch_metric_mon #(.N(NB), .MODE(CODE_DECOMP), .M(2)) dut_d2 (
        .clk(clk), .rst(rst), .clr_max(clr_max), .in_valid(in_valid), .in_code(in_code),
        .metric_valid(mv[4]), .metric(mt[4]), .max_metric(mx[4]));

    function automatic int model_seg(int m, int a, int b);
        int sh = NB - m;
        int ta = a >> sh;
        int tb = b >> sh;
        int d = (ta > tb) ? ta - tb : tb - ta;
        return (d << sh) + ((a ^ b) & ((1 << sh) - 1));
    endfunction

    // Mux form of the split: s=1 -> (all ones, L), s=0 -> (L, zero)
    function automatic int model_dec(int a, int b, int w, int lay);
        int msk = (1 << (w - 1)) - 1;
        int sa = (a >> (w - 1)) & 1;
        int sb = (b >> (w - 1)) & 1;
        int la = a & msk;
        int lb = b & msk;
        if (lay == 0) return (a ^ b) & ((1 << w) - 1);
        return ((sa != sb) ? 1 : 0)
             + model_dec(sa ? msk : la, sb ? msk : lb, w - 1, lay - 1)
             + model_dec(sa ? la : 0, sb ? lb : 0, w - 1, lay - 1);
    endfunction

    function automatic int model(int k, int a, int b);
        case (k)
            0: return a ^ b;
            1: return model_seg(2, a, b);
            2: return model_seg(3, a, b);
            3: return model_dec(a, b, NB, 1);
            default: return model_dec(a, b, NB, 2);
        endcase
    endfunction

    function automatic string mode_req(int k);
        if (k == 0) return "R3";
        if (k < 3) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input int k, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s dut%0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; clr_max = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        have_prev = 0;
        for (int k = 0; k < ND; k++) maxe[k] = 0;
    endtask

    task automatic step(input bit v, input int c, input bit clr);
        bit pv = v && have_prev;
        int em [ND];
        for (int k = 0; k < ND; k++) begin
            em[k] = pv ? model(k, prev_code, c) : 0;
            if (clr) maxe[k] = 0;
            else if (pv && em[k] > maxe[k]) maxe[k] = em[k];
        end
        @(negedge clk);
        in_valid = v; in_code = NB'(c); clr_max = clr;
        @(posedge clk);
        #1;
        for (int k = 0; k < ND; k++) begin
            chk("R2", k, int'(mv[k]), int'(pv));
            if (pv) chk(mode_req(k), k, int'(mt[k]), em[k]);
            chk("R8", k, int'(mx[k]), maxe[k]);
        end
        if (v) begin
            prev_code = c;
            have_prev = 1;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int x;
        do_reset();
        #1;
        for (int k = 0; k < ND; k++) begin
            chk("R1", k, int'(mv[k]), 0);
            chk("R1", k, int'(mt[k]), 0);
            chk("R1", k, int'(mx[k]), 0);
        end

        // R6 corner pair 31 -> 32
        step(1, 31, 0);
        step(1, 32, 0);
        chk("R6", 0, int'(mt[0]), 63);
        chk("R6", 1, int'(mt[1]), 31);
        chk("R6", 3, int'(mt[3]), 1);

        // R7 ascending exhaustive sweep
        do_reset();
        for (int c = 0; c < 64; c++) step(1, c, 0);
        chk("R7", 3, int'(mx[3]), int'(mx[1]));
        chk("R7", 4, int'(mx[4]), int'(mx[2]));
        chk("R7", 0, int'(mx[0]), maxe[0]);

        // descending sweep after clearing the maximum
        step(0, 0, 1);
        for (int c = 63; c >= 0; c--) step(1, c, 0);

        // R9 repeated code
        step(1, 21, 0);
        step(1, 21, 0);
        for (int k = 0; k < ND; k++) chk("R9", k, int'(mt[k]), 0);

        // mixed stream: idle gaps, repeats, clears (some on valid pairs)
        x = 5;
        for (int i = 0; i < 160; i++) begin
            if (i % 7 == 3) step(0, x, 0);
            else if (i % 11 == 5) step(1, prev_code, 0);
            else begin
                x = (x * 37 + 11) & 63;
                step(1, x, (i % 40) == 17);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule